// File: doc/BRIEF.md
# I2C Target Address Recognizer

This block handles the address phase and direction control of an I2C target. It works on a bus that has already been synchronized, and it sees the bus only through three one-cycle strobes: a start (or repeated start) condition, a stop condition, and a received byte, which arrives together with `rxByte`. The block compares the first byte after a start, or the first two bytes in 10-bit mode, against a programmed own address. It then sets the acknowledge decision for the byte, chooses whether the target receives or transmits, and sets sticky event flags.

In 10-bit mode the block accepts the two-byte write sequence: a header of `11110`, the two top address bits and a write bit, followed by a byte that holds the low eight address bits. It remembers a completed write match. A later repeated start with the matching read header then switches the target to transmit without a second low byte. Recognition of the general call address can be enabled, and a general call sets its own flag.

The surrounding target logic reads `ackOut` after each byte strobe to drive the acknowledge bit, reads `dirTx` to steer the data shifter, and clears the flags by writing ones to `flagClr`.

Top module: `i2c_addr_match`

## Requirements
- R1: In 7-bit mode (`cfgAddr10`=0), a first byte after a start whose bits [7:1] equal `cfgOwnAddr[6:0]` is acknowledged (`ackOut`=1 the cycle after the byte strobe). It sets the start flag (flags bit 0), and bit 0 of the byte sets `dirTx` (0 = receive, 1 = transmit).
- R2: A 7-bit read match (bit 0 = 1) also sets the transmit-ready flag (flags bit 3). While the target transmits, each later byte strobe sets flags bit 3 again and gives `ackOut`=0.
- R3: In 10-bit mode the first byte is acknowledged only if bits [7:3] are 11110 and bits [2:1] equal `cfgOwnAddr[9:8]`. A header with other top bits is not acknowledged.
- R4: After a matching 10-bit write header, a second byte equal to `cfgOwnAddr[7:0]` is acknowledged. It sets the start flag, clears `dirTx` and records a completed 10-bit match. A second byte that differs is not acknowledged.
- R5: While the target is addressed as a receiver, every byte strobe is acknowledged and sets the receive-ready flag (flags bit 2).
- R6: A 10-bit read header (bit 0 = 1) is acknowledged only while a completed 10-bit match is recorded. It then sets `dirTx`=1, the start flag and the transmit-ready flag. Without a recorded match it is not acknowledged.
- R7: With `cfgGcEn`=1, the byte 0x00 after a start is acknowledged in either mode. It clears `dirTx` and sets the start flag and the general-call flag (flags bit 4). With `cfgGcEn`=0 it is not acknowledged.
- R8: The stop flag (flags bit 1) is set only by a stop strobe that arrives while the target is addressed. Address bytes, data bytes and a stop while not addressed leave it clear.
- R9: After a byte that fails to match, every following byte strobe gives `ackOut`=0 and sets no flag until the next start or stop.
- R10: Every start strobe clears the general-call flag.
- R11: Flags stay set until a 1 is written to the matching bit of `flagClr`. When a set and a clear of the same flag fall in one cycle, the set wins.
- R12: The recorded 10-bit match is cleared by a stop, by a new 10-bit write header, and by a header that fails to match. A later read header is then not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Start or repeated start seen (one cycle) |
| stopStb | input | 1 | Stop seen (one cycle); takes priority over the other strobes |
| byteStb | input | 1 | A byte has been received on `rxByte` (one cycle) |
| rxByte | input | 8 | Received byte, valid with `byteStb` |
| cfgAddr10 | input | 1 | 1 selects 10-bit addressing |
| cfgGcEn | input | 1 | 1 enables general call recognition |
| cfgOwnAddr | input | 10 | Own address (bits [6:0] are used in 7-bit mode) |
| flagClr | input | 5 | Write-one-to-clear for the flags |
| ackOut | output | 1 | Acknowledge decision for the last byte; cleared by start and stop |
| dirTx | output | 1 | 1 = transmit, 0 = receive |
| flags | output | 5 | bit0 start, bit1 stop, bit2 receive ready, bit3 transmit ready, bit4 general call |

## Verification
Assertions check on every cycle the following:
- A stop always wipes the recorded 10-bit match.
- A stop request from the control sets the stop flag.
- An ignored state never acknowledges.
- A read header without a recorded match never raises the start flag.
- A start clears the general-call flag unless a general call sets it in the same cycle.
- Flags hold while they are not cleared.

Only the bench scenarios show the full 10-bit write-then-read sequence, the loss of the match after a failed header, and the address compares against concrete own addresses. The same holds for the acknowledge pattern over whole transactions. The bench shows these by running every cycle against a behavioural model.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
  localparam int BYTE_W = 8;
  localparam int FLAG_N = 5;
  localparam int F_START = 0;
  localparam int F_STOP  = 1;
  localparam int F_RX    = 2;
  localparam int F_TX    = 3;
  localparam int F_GC    = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_LOW10, ST_DATA, ST_IGNORE
  } stateT;

  typedef struct packed {
    logic setStart;
    logic setStop;
    logic setRx;
    logic setTx;
    logic setGc;
    logic clrGc;
    logic ackLd;
    logic ackVal;
    logic dirLd;
    logic dirVal;
  } strbT;
endpackage

// File: rtl/i2c_addr_dp.sv
module i2c_addr_dp
  import i2c_addr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [ADDR_W-1:0] cfgOwnAddr,
  input  logic              cfgGcEn,
  input  logic [FLAG_N-1:0] flagClr,
  input  strbT              strb,
  output logic              hit7,
  output logic              hitGc,
  output logic              hdrTop,
  output logic              rxRead,
  output logic              lowHit,
  output logic              ackOut,
  output logic              dirTx,
  output logic [FLAG_N-1:0] flags
);
  localparam int LOW_W = BYTE_W;
  localparam int HI_W  = ADDR_W - LOW_W;

  logic [FLAG_N-1:0] setVec;
  logic [FLAG_N-1:0] clrVec;

  assign hit7   = rxByte[BYTE_W-1:1] == cfgOwnAddr[BYTE_W-2:0];
  assign hitGc  = cfgGcEn && (rxByte == '0);
  assign hdrTop = (rxByte[BYTE_W-1:HI_W+1] == 5'b11110) &&
                  (rxByte[HI_W:1] == cfgOwnAddr[ADDR_W-1:LOW_W]);
  assign rxRead = rxByte[0];
  assign lowHit = rxByte == cfgOwnAddr[LOW_W-1:0];

  always_comb begin
    setVec = '0;
    setVec[F_START] = strb.setStart;
    setVec[F_STOP]  = strb.setStop;
    setVec[F_RX]    = strb.setRx;
    setVec[F_TX]    = strb.setTx;
    setVec[F_GC]    = strb.setGc;
    clrVec = flagClr;
    clrVec[F_GC] = flagClr[F_GC] | strb.clrGc;
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) flags[i] <= 1'b0;
      else       flags[i] <= (flags[i] & ~clrVec[i]) | setVec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackOut <= 1'b0;
      dirTx  <= 1'b0;
    end else begin
      if (strb.ackLd) ackOut <= strb.ackVal;
      if (strb.dirLd) dirTx  <= strb.dirVal;
    end
  end

  p_stop_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.setStop |=> flags[F_STOP]);
  p_gc_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrGc && !strb.setGc) |=> !flags[F_GC]);
  p_sticky_rx_r11: assert property (@(posedge clk) disable iff (!rstN)
    (flags[F_RX] && !flagClr[F_RX]) |=> flags[F_RX]);
endmodule

// File: rtl/i2c_addr_ctrl.sv
module i2c_addr_ctrl
  import i2c_addr_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic startStb,
  input  logic stopStb,
  input  logic byteStb,
  input  logic cfgAddr10,
  input  logic hit7,
  input  logic hitGc,
  input  logic hdrTop,
  input  logic rxRead,
  input  logic lowHit,
  input  logic dirTx,
  output strbT strb
);
  stateT stateQ, stateD;
  logic  match10Q, match10D;

  always_comb begin
    strb     = '0;
    stateD   = stateQ;
    match10D = match10Q;
    if (stopStb) begin
      strb.setStop = (stateQ == ST_DATA);
      strb.ackLd   = 1'b1;
      stateD       = ST_IDLE;
      match10D     = 1'b0;
    end else if (startStb) begin
      strb.clrGc = 1'b1;
      strb.ackLd = 1'b1;
      stateD     = ST_HDR;
    end else if (byteStb) begin
      strb.ackLd = 1'b1;
      unique case (stateQ)
        ST_HDR: begin
          stateD = ST_IGNORE;
          if (hitGc) begin
            strb.ackVal = 1'b1;  strb.setStart = 1'b1; strb.setGc = 1'b1;
            strb.dirLd  = 1'b1;  strb.dirVal   = 1'b0; stateD     = ST_DATA;
          end else if (!cfgAddr10) begin
            if (hit7) begin
              strb.ackVal = 1'b1;  strb.setStart = 1'b1; strb.setTx = rxRead;
              strb.dirLd  = 1'b1;  strb.dirVal   = rxRead; stateD   = ST_DATA;
            end
          end else begin
            match10D = 1'b0;
            if (hdrTop && !rxRead) begin
              strb.ackVal = 1'b1;
              stateD      = ST_LOW10;
            end else if (hdrTop && rxRead && match10Q) begin
              strb.ackVal = 1'b1;  strb.setStart = 1'b1; strb.setTx = 1'b1;
              strb.dirLd  = 1'b1;  strb.dirVal   = 1'b1; stateD     = ST_DATA;
              match10D    = 1'b1;
            end
          end
        end
        ST_LOW10: begin
          if (lowHit) begin
            strb.ackVal = 1'b1;  strb.setStart = 1'b1;
            strb.dirLd  = 1'b1;  strb.dirVal   = 1'b0;
            stateD      = ST_DATA; match10D    = 1'b1;
          end else begin
            stateD = ST_IGNORE;
          end
        end
        ST_DATA: begin
          if (dirTx) strb.setTx = 1'b1;
          else begin
            strb.ackVal = 1'b1;
            strb.setRx  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      match10Q <= 1'b0;
    end else begin
      stateQ   <= stateD;
      match10Q <= match10D;
    end
  end

  p_stop_clears_m10_r12: assert property (@(posedge clk) disable iff (!rstN)
    stopStb |=> !match10Q);
  p_ignore_nack_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IGNORE && byteStb && !startStb && !stopStb)
      |-> (!strb.ackVal && !strb.setStart && !strb.setRx));
  p_read_needs_m10_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HDR && byteStb && !startStb && !stopStb && cfgAddr10 &&
     !hitGc && rxRead && !match10Q) |-> !strb.setStart);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_addr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic              stopStb,
  input  logic              byteStb,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              cfgAddr10,
  input  logic              cfgGcEn,
  input  logic [ADDR_W-1:0] cfgOwnAddr,
  input  logic [FLAG_N-1:0] flagClr,
  output logic              ackOut,
  output logic              dirTx,
  output logic [FLAG_N-1:0] flags
);
  strbT strb;
  logic hit7, hitGc, hdrTop, rxRead, lowHit;

  i2c_addr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .stopStb(stopStb),
    .byteStb(byteStb), .cfgAddr10(cfgAddr10), .hit7(hit7), .hitGc(hitGc),
    .hdrTop(hdrTop), .rxRead(rxRead), .lowHit(lowHit), .dirTx(dirTx),
    .strb(strb)
  );

  i2c_addr_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .cfgOwnAddr(cfgOwnAddr),
    .cfgGcEn(cfgGcEn), .flagClr(flagClr), .strb(strb), .hit7(hit7),
    .hitGc(hitGc), .hdrTop(hdrTop), .rxRead(rxRead), .lowHit(lowHit),
    .ackOut(ackOut), .dirTx(dirTx), .flags(flags)
  );
endmodule

// File: tb/i2c_addr_match_tb.sv
`timescale 1ns/1ps
module i2c_addr_match_tb;
  logic clk = 0, rstN = 0;
  logic startStb = 0, stopStb = 0, byteStb = 0;
  logic [7:0] rxByte = 0;
  logic cfgAddr10 = 0, cfgGcEn = 0;
  logic [9:0] cfgOwnAddr = 10'h02A;
  logic [4:0] flagClr = 0;
  logic ackOut, dirTx;
  logic [4:0] flags;

  int nRun = 0, nFail = 0;

  always #4 clk = ~clk;

  i2c_addr_match u_dut (.*);

  // behavioural reference: 0 idle, 1 header, 2 low byte, 3 addressed, 4 ignore
  int mSt = 0;
  bit mM10 = 0, mAck = 0, mDir = 0;
  bit [4:0] mFlg = 0;

  always @(posedge clk) begin
    bit [4:0] setF, clrF;
    if (!rstN) begin
      mSt = 0; mM10 = 0; mAck = 0; mDir = 0; mFlg = 0;
    end else begin
      setF = 0; clrF = flagClr;
      if (stopStb) begin
        if (mSt == 3) setF[1] = 1;
        mSt = 0; mM10 = 0; mAck = 0;
      end else if (startStb) begin
        clrF[4] = 1; mSt = 1; mAck = 0;
      end else if (byteStb) begin
        mAck = 0;
        if (mSt == 1) begin
          mSt = 4;
          if (cfgGcEn && rxByte == 8'h00) begin
            mAck = 1; mDir = 0; mSt = 3; setF[0] = 1; setF[4] = 1;
          end else if (!cfgAddr10) begin
            if (rxByte[7:1] == cfgOwnAddr[6:0]) begin
              mAck = 1; mDir = rxByte[0]; mSt = 3; setF[0] = 1;
              if (rxByte[0]) setF[3] = 1;
            end
          end else begin
            bit top;
            bit old;
            top = (rxByte[7:3] == 5'b11110) && (rxByte[2:1] == cfgOwnAddr[9:8]);
            old = mM10; mM10 = 0;
            if (top && !rxByte[0]) begin mAck = 1; mSt = 2; end
            else if (top && old) begin
              mAck = 1; mDir = 1; mSt = 3; mM10 = 1; setF[0] = 1; setF[3] = 1;
            end
          end
        end else if (mSt == 2) begin
          if (rxByte == cfgOwnAddr[7:0]) begin
            mAck = 1; mDir = 0; mSt = 3; mM10 = 1; setF[0] = 1;
          end else mSt = 4;
        end else if (mSt == 3) begin
          if (mDir) setF[3] = 1;
          else begin mAck = 1; setF[2] = 1; end
        end
      end
      mFlg = (mFlg & ~clrF) | setF;
    end
  end

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual ack/dir/flags=%b expected %b", tag, act, exp);
    end
  endtask

  // drive one cycle at a negedge, observe at the following negedge
  task automatic step(string tag, bit st, bit sp, bit bs, logic [7:0] b, logic [4:0] c = 0);
    startStb = st; stopStb = sp; byteStb = bs; rxByte = b; flagClr = c;
    @(negedge clk);
    startStb = 0; stopStb = 0; byteStb = 0; flagClr = 0;
    chk(tag, {ackOut, dirTx, flags}, {mAck, mDir, mFlg});
  endtask

  task automatic clrAll();
    step("R11", 0, 0, 0, 8'h00, 5'h1F);
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    chk("reset", {ackOut, dirTx, flags}, 7'b0);
    // 7-bit write, data, stop
    step("R1", 1, 0, 0, 0);
    step("R1", 0, 0, 1, 8'h54);
    chk("R1 direct", {ackOut, dirTx, flags}, 7'b10_00001);
    step("R8", 0, 0, 1, 8'h11);
    step("R5", 0, 0, 1, 8'h22);
    chk("R5 direct", {ackOut, flags[2], flags[1]}, 7'b0000110);
    step("R8", 0, 1, 0, 0);
    chk("R8 direct", {1'b0, flags[1]}, 7'b1);
    clrAll();
    chk("R11 direct", {2'b0, flags}, 7'b0);
    // 7-bit read
    step("R2", 1, 0, 0, 0);
    step("R2", 0, 0, 1, 8'h55);
    chk("R2 direct", {ackOut, dirTx, flags}, 7'b11_01001);
    step("R2", 0, 0, 1, 8'hA5, 5'h08);
    chk("R11 set wins", {ackOut, flags[3]}, 7'b1);
    step("R8", 0, 1, 0, 0);
    clrAll();
    // mismatch
    step("R9", 1, 0, 0, 0);
    step("R9", 0, 0, 1, 8'h56);
    step("R9", 0, 0, 1, 8'h54);
    step("R9", 0, 0, 1, 8'h00);
    chk("R9 direct", {ackOut, 1'b0, flags}, 7'b0);
    step("R8", 0, 1, 0, 0);
    chk("R8 unaddressed", {2'b0, flags}, 7'b0);
    // general call
    step("R7", 1, 0, 0, 0);
    step("R7", 0, 0, 1, 8'h00);
    chk("R7 disabled", {ackOut, 6'b0}, 7'b0);
    cfgGcEn = 1;
    step("R7", 1, 0, 0, 0);
    step("R7", 0, 0, 1, 8'h00);
    chk("R7 direct", {ackOut, dirTx, flags}, 7'b10_10001);
    step("R5", 0, 0, 1, 8'h33);
    step("R10", 1, 0, 0, 0);
    chk("R10 direct", {6'b0, flags[4]}, 7'b0);
    step("R8", 0, 1, 0, 0);
    clrAll();
    // 10-bit own address 0x2B5: write header F4, read header F5, low B5
    cfgAddr10 = 1; cfgOwnAddr = 10'h2B5;
    step("R3", 1, 0, 0, 0);
    step("R3", 0, 0, 1, 8'hF4);
    chk("R3 direct", {ackOut, dirTx, flags}, 7'b10_00000);
    step("R4", 0, 0, 1, 8'hB5);
    chk("R4 direct", {ackOut, dirTx, flags}, 7'b10_00001);
    step("R5", 0, 0, 1, 8'h44);
    step("R6", 1, 0, 0, 0);
    step("R6", 0, 0, 1, 8'hF5);
    chk("R6 direct", {ackOut, dirTx, flags}, 7'b11_01101);
    step("R2", 0, 0, 1, 8'h12);
    step("R8", 0, 1, 0, 0);
    clrAll();
    // read header after stop: match forgotten
    step("R12", 1, 0, 0, 0);
    step("R12", 0, 0, 1, 8'hF5);
    chk("R12 after stop", {ackOut, 6'b0}, 7'b0);
    step("R12", 0, 1, 0, 0);
    // wrong top bits, wrong low byte
    step("R3", 1, 0, 0, 0);
    step("R3", 0, 0, 1, 8'hF2);
    chk("R3 wrong top", {ackOut, 6'b0}, 7'b0);
    step("R4", 1, 0, 0, 0);
    step("R4", 0, 0, 1, 8'hF4);
    step("R4", 0, 0, 1, 8'hB4);
    chk("R4 wrong low", {ackOut, 1'b0, flags}, 7'b0);
    step("R9", 0, 0, 1, 8'hB5);
    // match then failed repeated header clears memory
    step("R12", 1, 0, 0, 0);
    step("R12", 0, 0, 1, 8'hF4);
    step("R12", 0, 0, 1, 8'hB5);
    step("R12", 1, 0, 0, 0);
    step("R12", 0, 0, 1, 8'hF2);
    step("R12", 1, 0, 0, 0);
    step("R12", 0, 0, 1, 8'hF5);
    chk("R12 failed header", {ackOut, 6'b0}, 7'b0);
    step("R12", 0, 1, 0, 0);
    // general call in 10-bit mode
    step("R7", 1, 0, 0, 0);
    step("R7", 0, 0, 1, 8'h00);
    chk("R7 10-bit", {ackOut, 5'b0, flags[4]}, 7'b1000001);
    step("R8", 0, 1, 0, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule